// File: doc/BRIEF.md
# Selectable-Event Performance Counter Bank

This block holds four 64-bit event counters that watch a shared second-level cache. Every cycle the cache pipeline presents a vector of single-cycle event pulses. Each counter has its own event code that picks one pulse line to count. Code 0 is special: it counts every clock cycle. Software programs each counter and reads it back through a small register port. A read returns its data one cycle after the request.

Each counter also has a clear-on-read option. When it is set, a read of the counter returns the value it held and restarts the count from zero. An event that lands in the same cycle as that read is kept. Rewriting a counter's configuration changes what it counts from the next cycle on. The value already counted is kept.

Top module: `perf_counter_bank`

## Requirements
- R1: There are four counters, chosen by `reg_addr[1:0]`. `reg_addr[2]` = 0 selects a counter's configuration word and `reg_addr[2]` = 1 selects its count value.
- R2: The configuration word holds the event code in bits [5:0] and the clear-on-read enable in bit 8. Reading it back returns those two fields, with every other bit at 0.
- R3: Event code 0 adds one to the counter on every clock cycle.
- R4: Event codes 1 to 53 add one in each cycle where `evt_in[code]` is high. `evt_in[0]` is never counted.
- R5: Event codes 54 to 63 count nothing.
- R6: A read sampled at one clock edge sets `reg_rvalid` after that edge and drives the selected word on `reg_rdata`. A count read returns the value from before that cycle's event. When no read is in progress, `reg_rvalid` and `reg_rdata` are 0.
- R7: When clear-on-read is set, a count read restarts the counter. After the read the counter holds 0, plus 1 if its event fired in the read cycle.
- R8: When clear-on-read is clear, a count read leaves the counter running undisturbed.
- R9: Writing a counter's configuration word leaves its accumulated count unchanged. The new event code takes effect from the following cycle.
- R10: Writes to count-value addresses are ignored.
- R11: Counters wrap modulo 2^CNT_W and give no overflow indication.
- R12: Reset clears every count, sets every event code to 0 with clear-on-read disabled, and clears `reg_rvalid` and `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Bit 2 selects configuration (0) or count (1); bits [1:0] select the counter index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid together with reg_rvalid |
| reg_rvalid | output | 1 | High in the cycle after a sampled read |
| evt_in | input | 54 | Single-cycle event pulses, one line per event code |

## Verification
The two hardest cases are an event arriving in the same cycle as a clearing read, and the wrap at the top of the counter range. For the first, the bench holds the selected event high across the read cycle and then reads the counter again, expecting a count of exactly one more per cycle. A 64-bit counter cannot be driven to its wrap point from the ports in a short run. The bench therefore also builds a second instance with a 10-bit count, clears a cycle-counting counter with a read, and reads it again 1030 cycles later. The expected value is 6. The scoreboard model tracks every counter through a long stretch of pseudo-random pulses mixed with reads and writes, including writes to count addresses and codes above 53.

// File: rtl/perf_pkg.sv
package perf_pkg;
    localparam int COR_BIT = 8;

    typedef enum logic {
        REGION_CFG = 1'b0,
        REGION_CNT = 1'b1
    } region_e;
endpackage

// File: rtl/perf_evt_mux.sv
module perf_evt_mux #(
    parameter int NUM_EVT = 54,
    parameter int SEL_W   = 6
) (
    input  logic [NUM_EVT-1:0] evts,
    input  logic [SEL_W-1:0]   sel,
    output logic               hit
);
    localparam int PAD_W = 2 ** SEL_W;

    logic [PAD_W-1:0] pad;
    logic             unused_bit0;

    assign unused_bit0 = evts[0];

    always_comb begin
        pad                = '0;
        pad[NUM_EVT-1:1]   = evts[NUM_EVT-1:1];
        pad[0]             = 1'b1;
        hit                = pad[sel];
    end
endmodule

// File: rtl/perf_cnt_slot.sv
module perf_cnt_slot #(
    parameter int CNT_W = 64,
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_cor,
    input  logic             rd_cnt,
    input  logic             hit,
    output logic [CNT_W-1:0] cnt,
    output logic [SEL_W-1:0] sel,
    output logic             cor
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
        logic             cor;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_cnt && st_q.cor) begin
            st_d.cnt = CNT_W'(hit);
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(hit);
        end
        if (cfg_we) begin
            st_d.sel = cfg_sel;
            st_d.cor = cfg_cor;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign sel = st_q.sel;
    assign cor = st_q.cor;
endmodule

// File: rtl/perf_reg_if.sv
module perf_reg_if
    import perf_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 64,
    parameter int SEL_W   = 6,
    parameter int IDX_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr,
    input  logic                            reg_rd,
    input  logic [IDX_W:0]                  reg_addr,
    input  logic [CNT_W-1:0]                reg_wdata,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all,
    input  logic [NUM_CNT-1:0][SEL_W-1:0]   sel_all,
    input  logic [NUM_CNT-1:0]              cor_all,
    output logic [NUM_CNT-1:0]              cfg_we,
    output logic [NUM_CNT-1:0]              rd_cnt,
    output logic [SEL_W-1:0]                cfg_sel,
    output logic                            cfg_cor,
    output logic [CNT_W-1:0]                reg_rdata,
    output logic                            reg_rvalid
);
    typedef struct packed {
        logic [CNT_W-1:0] rdata;
        logic             rvalid;
    } rb_t;

    rb_t               rb_d, rb_q;
    region_e           region;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  cfg_word;
    logic              unused_wdata;

    assign region       = region_e'(reg_addr[IDX_W]);
    assign idx          = reg_addr[IDX_W-1:0];
    assign cfg_sel      = reg_wdata[SEL_W-1:0];
    assign cfg_cor      = reg_wdata[COR_BIT];
    assign unused_wdata = ^{reg_wdata[CNT_W-1:COR_BIT+1], reg_wdata[COR_BIT-1:SEL_W]};

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
        assign cfg_we[i] = reg_wr && (region == REGION_CFG) && (idx == IDX_W'(i));
        assign rd_cnt[i] = reg_rd && (region == REGION_CNT) && (idx == IDX_W'(i));
    end

    always_comb begin
        cfg_word          = '0;
        cfg_word[SEL_W-1:0] = sel_all[idx];
        cfg_word[COR_BIT] = cor_all[idx];
    end

    always_comb begin
        rb_d = '0;
        if (reg_rd) begin
            rb_d.rvalid = 1'b1;
            rb_d.rdata  = (region == REGION_CNT) ? cnt_all[idx] : cfg_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_q <= '0;
        end else begin
            rb_q <= rb_d;
        end
    end

    assign reg_rdata  = rb_q.rdata;
    assign reg_rvalid = rb_q.rvalid;
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 64,
    parameter int NUM_EVT = 54
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [$clog2(NUM_CNT):0]   reg_addr,
    input  logic [CNT_W-1:0]           reg_wdata,
    output logic [CNT_W-1:0]           reg_rdata,
    output logic                       reg_rvalid,
    input  logic [NUM_EVT-1:0]         evt_in
);
    localparam int IDX_W = $clog2(NUM_CNT);
    localparam int SEL_W = $clog2(NUM_EVT);

    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_CNT-1:0][SEL_W-1:0] sel_all;
    logic [NUM_CNT-1:0]            cor_all;
    logic [NUM_CNT-1:0]            cfg_we;
    logic [NUM_CNT-1:0]            rd_cnt;
    logic [NUM_CNT-1:0]            hit;
    logic [SEL_W-1:0]              cfg_sel;
    logic                          cfg_cor;

    perf_reg_if #(
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W),
        .SEL_W   (SEL_W),
        .IDX_W   (IDX_W)
    ) u_reg_if (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .cnt_all    (cnt_all),
        .sel_all    (sel_all),
        .cor_all    (cor_all),
        .cfg_we     (cfg_we),
        .rd_cnt     (rd_cnt),
        .cfg_sel    (cfg_sel),
        .cfg_cor    (cfg_cor),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
        perf_evt_mux #(
            .NUM_EVT (NUM_EVT),
            .SEL_W   (SEL_W)
        ) u_mux (
            .evts (evt_in),
            .sel  (sel_all[i]),
            .hit  (hit[i])
        );

        perf_cnt_slot #(
            .CNT_W (CNT_W),
            .SEL_W (SEL_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (cfg_we[i]),
            .cfg_sel (cfg_sel),
            .cfg_cor (cfg_cor),
            .rd_cnt  (rd_cnt[i]),
            .hit     (hit[i]),
            .cnt     (cnt_all[i]),
            .sel     (sel_all[i]),
            .cor     (cor_all[i])
        );
    end
endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 64,
    parameter int NUM_EVT = 54,
    parameter int IDX_W   = 2,
    parameter int SEL_W   = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr,
    input logic                          reg_rd,
    input logic [IDX_W:0]                reg_addr,
    input logic                          reg_rvalid,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all,
    input logic [NUM_CNT-1:0][SEL_W-1:0] sel_all,
    input logic [NUM_CNT-1:0]            cor_all
);
    assert_rvalid_follows_read_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
    assert_rvalid_idle_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        logic rd_i, we_i;
        assign rd_i = reg_rd && (reg_addr == {1'b1, IDX_W'(i)});
        assign we_i = reg_wr && (reg_addr == {1'b0, IDX_W'(i)});

        assert_clear_on_read_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i && cor_all[i]) |=> (cnt_all[i] <= CNT_W'(1)));

        assert_read_no_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i && !cor_all[i]) |=> ((cnt_all[i] - $past(cnt_all[i])) <= CNT_W'(1)));

        assert_cfg_keeps_count_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && !rd_i) |=> ((cnt_all[i] - $past(cnt_all[i])) <= CNT_W'(1)));

        assert_cycle_count_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            ((sel_all[i] == '0) && !rd_i) |=> ((cnt_all[i] - $past(cnt_all[i])) == CNT_W'(1)));

        assert_dead_code_R5 : assert property (@(posedge clk) disable iff (!rst_n)
            ((int'(sel_all[i]) >= NUM_EVT) && !rd_i) |=> $stable(cnt_all[i]));
    end
endmodule

bind perf_counter_bank perf_counter_bank_chk #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .NUM_EVT (NUM_EVT),
    .IDX_W   (IDX_W),
    .SEL_W   (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rvalid (reg_rvalid),
    .cnt_all    (cnt_all),
    .sel_all    (sel_all),
    .cor_all    (cor_all)
);

// File: tb/perf_counter_bank_bench.sv
module perf_counter_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NEVT = 54;

    typedef struct {
        logic [63:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        n_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [NEVT-1:0] evt = '0;
    logic [63:0] reg_rdata;
    logic        reg_rvalid;
    logic [9:0]  n_rdata;
    logic        n_rvalid;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_tag = "R6";
    exp_t  sb_q[$];

    logic [63:0] m_cnt [4];
    logic [5:0]  m_sel [4];
    logic        m_cor [4];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_counter_bank u_perf_counter_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .evt_in(evt)
    );

    perf_counter_bank #(.CNT_W(10)) u_perf_counter_bank_narrow (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(n_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata[9:0]), .reg_rdata(n_rdata),
        .reg_rvalid(n_rvalid), .evt_in(evt)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic model_hit(input logic [5:0] code, input logic [NEVT-1:0] e);
        if (code == 6'd0) return 1'b1;
        if (int'(code) < NEVT) return e[code];
        return 1'b0;
    endfunction

    // Reference model and expected-item producer
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_cnt[i] = '0; m_sel[i] = '0; m_cor[i] = 1'b0;
            end
        end else begin
            if (reg_rd) begin
                exp_t it;
                it.tag = cur_tag;
                if (reg_addr[2]) it.val = m_cnt[reg_addr[1:0]];
                else it.val = {55'd0, m_cor[reg_addr[1:0]], 2'b00, m_sel[reg_addr[1:0]]};
                sb_q.push_back(it);
            end
            for (int i = 0; i < 4; i++) begin
                logic inc, clr;
                inc = model_hit(m_sel[i], evt);
                clr = reg_rd && reg_addr[2] && (reg_addr[1:0] == 2'(i)) && m_cor[i];
                m_cnt[i] = (clr ? 64'd0 : m_cnt[i]) + 64'(inc);
            end
            if (reg_wr && !reg_addr[2]) begin
                m_sel[reg_addr[1:0]] = reg_wdata[5:0];
                m_cor[reg_addr[1:0]] = reg_wdata[8];
            end
        end
    end

    // Monitor: compare design results against the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_rvalid) begin
                if (sb_q.size() == 0) begin
                    check("R6 unexpected rvalid", 64'd1, 64'd0);
                end else begin
                    exp_t it;
                    it = sb_q.pop_front();
                    check(it.tag, reg_rdata, it.val);
                end
            end else begin
                check("R6 idle rdata", reg_rdata, 64'd0);
            end
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [2:0] a, input string tag);
        cur_tag = tag; reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle(3);
        check("R12 rvalid in reset", 64'(reg_rvalid), 64'd0);
        check("R12 rdata in reset", reg_rdata, 64'd0);
        rst_n = 1'b1;
        idle(1);
        // R12/R2: configuration after reset
        for (int i = 0; i < 4; i++) rd_reg({1'b0, 2'(i)}, "R12 cfg reset");
        // R3: counting cycles from reset
        rd_reg(3'b100, "R3 cycle count");
        rd_reg(3'b111, "R12 R3 count after reset");
        // R1/R2: program each counter
        wr_reg(3'b000, 64'h0000_0000_0000_0100);          // code 0, clear on read
        wr_reg(3'b001, 64'h0000_0000_0000_0005);          // code 5
        wr_reg(3'b010, 64'h0000_0000_0000_0135);          // code 53, clear on read
        wr_reg(3'b011, 64'hFFFF_0000_0000_0E3C);          // code 60, junk bits
        for (int i = 0; i < 4; i++) rd_reg({1'b0, 2'(i)}, "R1 R2 cfg readback");
        // R11: wrap on the 10-bit instance, counter 0 counts cycles with clear on read
        reg_addr = 3'b100; n_rd = 1'b1;
        @(negedge clk);
        n_rd = 1'b0;
        idle(1029);
        reg_addr = 3'b100; n_rd = 1'b1;
        @(negedge clk);
        n_rd = 1'b0;
        check("R11 wrap", 64'(n_rdata), 64'd6);
        check("R11 rvalid", 64'(n_rvalid), 64'd1);
        // R4/R5: shaped event patterns, with bit 0 toggling
        for (int k = 0; k < 40; k++) begin
            evt = '0;
            evt[0] = k[0];
            evt[5] = (k % 3 == 0);
            evt[53] = (k % 2 == 0);
            if (k % 7 == 0) evt = '1;
            @(negedge clk);
        end
        evt = '0;
        rd_reg(3'b101, "R4 code 5 count");
        rd_reg(3'b110, "R4 R7 code 53 count");
        rd_reg(3'b110, "R7 cleared count");
        rd_reg(3'b111, "R5 dead code count");
        rd_reg(3'b100, "R7 R3 cycle clear");
        rd_reg(3'b100, "R7 second read");
        rd_reg(3'b101, "R8 no clear first");
        rd_reg(3'b101, "R8 no clear second");
        // R7: event pulse coincides with the clearing read
        evt[53] = 1'b1;
        idle(4);
        rd_reg(3'b110, "R7 read with event");
        evt[53] = 1'b0;
        rd_reg(3'b110, "R7 event kept");
        // R9: rewrite config keeps count
        evt[5] = 1'b1;
        idle(6);
        wr_reg(3'b001, 64'h0000_0000_0000_0100);
        evt[5] = 1'b0;
        rd_reg(3'b101, "R9 count kept after cfg write");
        // R10: writes to count addresses ignored
        wr_reg(3'b101, 64'h1234_5678_9ABC_DEF0);
        wr_reg(3'b111, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_reg(3'b101, "R10 count write ignored");
        rd_reg(3'b111, "R10 R5 count write ignored");
        // Mixed pseudo-random phase
        wr_reg(3'b011, 64'h0000_0000_0000_0121);          // code 33, clear on read
        wr_reg(3'b001, 64'h0000_0000_0000_0002);          // code 2
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            evt = {lfsr[5:0], lfsr, lfsr, lfsr};
            if (lfsr[3:0] == 4'd3) rd_reg({1'b1, lfsr[5:4]}, "R4 R7 R8 random read");
            else if (lfsr[3:0] == 4'd9) rd_reg({1'b0, lfsr[5:4]}, "R2 random cfg read");
            else if (lfsr[3:0] == 4'd12) wr_reg({1'b0, lfsr[5:4]},
                                                {55'd0, lfsr[6], 2'b00, lfsr[15:10]});
            else @(negedge clk);
        end
        evt = '0;
        for (int i = 0; i < 4; i++) rd_reg({1'b1, 2'(i)}, "R4 final count");
        idle(3);
        check("R6 scoreboard drained", 64'(sb_q.size()), 64'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule